// File: doc/BRIEF.md
# Quad-Word Store Beat Sequencer

This block carries out a 128-bit store instruction on a core whose memory write port is only 32 bits wide. When the core presents a decoded store with a start strobe, the block forms the effective address and checks that it sits on a 16-byte boundary. It then issues four 32-bit write beats on a valid/ready port and reports a single retire. A misaligned store produces one fault pulse and writes nothing.

Only the low 32 bits of the source register reach the block. Beat 0 carries those bits, and beats 1 to 3 carry zero. The common case of storing register zero therefore clears all sixteen target bytes exactly. The store never writes back to a general-purpose register.

The write port follows the usual valid/ready rules. A beat completes in a cycle where `wr_valid` and `wr_ready` are both high. While `wr_valid` is high and `wr_ready` is low, the address and data are held unchanged. `wr_valid` never drops before its beat completes. `wr_ready` may be high or low at any time.

Top module: `qstore_seq`

## Requirements
- R1: A store is accepted only when `start` is high, `busy` is low and `insn[31:26]` equals 6'h1F. Any other opcode on a start causes no beat, no retire and no fault.
- R2: The effective address is `base_val` plus `insn[15:0]` sign-extended to 32 bits.
- R3: If effective-address bits [3:0] are not all zero, `addr_fault` pulses for one cycle, in the cycle after the start, and no write beat is issued (STRICT_TRAP=0).
- R4: An aligned store issues exactly four beats, starting the cycle after the start, at addresses ea, ea+4, ea+8 and ea+12, in that order.
- R5: The beat-0 data is the low 32 bits of `src_val` captured at the start. Beats 1, 2 and 3 carry zero, so storing register zero clears all 16 bytes.
- R6: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged in the next cycle.
- R7: `retire` pulses for exactly one cycle, in the cycle after the fourth beat's handshake. In that same cycle the block is idle again.
- R8: `busy` is high from the cycle after an aligned start until the fourth handshake. A `start` while busy is ignored.
- R9: After reset, `busy`, `wr_valid`, `retire`, `addr_fault` and `hard_trap` are low. Every accepted store begins again at beat 0.
- R10: With STRICT_TRAP=1, a misaligned store pulses `hard_trap` instead of `addr_fault`, with the same timing, and issues no beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction-present strobe |
| insn | input | 32 | Decoded instruction word |
| base_val | input | 32 | Base register value |
| src_val | input | 32 | Low 32 bits of the source register |
| busy | output | 1 | Store in progress |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write port accepts beat |
| wr_addr | output | 32 | Beat byte address |
| wr_data | output | 32 | Beat data |
| retire | output | 1 | One-cycle completion pulse |
| addr_fault | output | 1 | Misaligned-store exception pulse |
| hard_trap | output | 1 | Misaligned-store trap pulse (strict build) |

## Verification
Storing register zero over memory preloaded with non-zero words shows whether every one of the four beats lands, because a missing beat leaves a non-zero word behind. A non-zero source with a negative offset and a stalling ready pattern separates the sign extension, the beat-0 data lane and the hold behaviour under back-pressure. Misaligned offsets, a foreign opcode, and a start raised while busy each check that the matching stimulus leaves the port silent. Back-to-back stores check that the beat counter restarts. Two builds, one per fault mode, tell the exception pulse apart from the trap pulse.

// File: rtl/qs_pkg.sv
package qs_pkg;
  typedef enum logic [0:0] {
    ST_FETCH_REQ = 1'b0,
    ST_WRITE     = 1'b1
  } qs_state_e;

  localparam logic [5:0] OPC_QSTORE = 6'h1F;
endpackage

// File: rtl/qs_ea_calc.sv
module qs_ea_calc #(
  parameter int ADDR_W  = 32,
  parameter int ALIGN_W = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [15:0]       imm,
  output logic [ADDR_W-1:0] ea,
  output logic              misaligned
);
  logic [ADDR_W-1:0] imm_sx;

  assign imm_sx     = {{(ADDR_W-16){imm[15]}}, imm};
  assign ea         = base + imm_sx;
  assign misaligned = |ea[ALIGN_W-1:0];
endmodule

// File: rtl/qs_beat_ctr.sv
module qs_beat_ctr #(
  parameter int BEATS = 4,
  localparam int BW   = $clog2(BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  output logic [BW-1:0] beat,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (!rst_n)       beat <= '0;
    else if (clear)   beat <= '0;
    else if (advance) beat <= (beat == BW'(BEATS-1)) ? '0 : beat + 1'b1;
  end

  assign last = (beat == BW'(BEATS-1));

  // R4: the beat index moves only on a handshake or a new store
  assert_ctr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !advance) |=> $stable(beat));
  // R9: a new store always begins at beat 0
  assert_ctr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (beat == '0));
endmodule

// File: rtl/qs_beat_mux.sv
module qs_beat_mux #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int BW      = 2,
  parameter int LANE_SH = 2
) (
  input  logic [ADDR_W-1:0] ea_q,
  input  logic [DATA_W-1:0] src_q,
  input  logic [BW-1:0]     beat,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  assign addr = ea_q + (ADDR_W'(beat) << LANE_SH);
  assign data = (beat == '0) ? src_q : '0;
endmodule

// File: rtl/qstore_seq.sv
module qstore_seq
  import qs_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BEATS       = 4,
  parameter bit STRICT_TRAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       insn,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [DATA_W-1:0] src_val,
  output logic              busy,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              retire,
  output logic              addr_fault,
  output logic              hard_trap
);
  localparam int BW      = $clog2(BEATS);
  localparam int LANE_SH = $clog2(DATA_W/8);
  localparam int ALIGN_W = BW + LANE_SH;

  qs_state_e         state_q;
  logic [ADDR_W-1:0] ea_q, ea_w;
  logic [DATA_W-1:0] src_q;
  logic              misaligned_w, accept, hs, last;
  logic [BW-1:0]     beat;
  logic              retire_q, fault_q, trap_q;

  qs_ea_calc #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_ea (
    .base(base_val), .imm(insn[15:0]), .ea(ea_w), .misaligned(misaligned_w)
  );

  assign accept = (state_q == ST_FETCH_REQ) && start && (insn[31:26] == OPC_QSTORE);
  assign hs     = wr_valid && wr_ready;

  qs_beat_ctr #(.BEATS(BEATS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear(accept), .advance(hs),
    .beat(beat), .last(last)
  );

  qs_beat_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BW(BW), .LANE_SH(LANE_SH)) u_mux (
    .ea_q(ea_q), .src_q(src_q), .beat(beat), .addr(wr_addr), .data(wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_FETCH_REQ;
      ea_q     <= '0;
      src_q    <= '0;
      retire_q <= 1'b0;
      fault_q  <= 1'b0;
      trap_q   <= 1'b0;
    end else begin
      retire_q <= 1'b0;
      fault_q  <= 1'b0;
      trap_q   <= 1'b0;
      case (state_q)
        ST_FETCH_REQ: begin
          if (accept) begin
            if (misaligned_w) begin
              if (STRICT_TRAP) trap_q  <= 1'b1;
              else             fault_q <= 1'b1;
            end else begin
              state_q <= ST_WRITE;
              ea_q    <= ea_w;
              src_q   <= src_val;
            end
          end
        end
        ST_WRITE: begin
          if (hs && last) begin
            state_q  <= ST_FETCH_REQ;
            retire_q <= 1'b1;
          end
        end
        default: state_q <= ST_FETCH_REQ;
      endcase
    end
  end

  assign busy       = (state_q == ST_WRITE);
  assign wr_valid   = (state_q == ST_WRITE);
  assign retire     = retire_q;
  assign addr_fault = fault_q;
  assign hard_trap  = trap_q;

  // R6: a stalled beat holds address and data
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R7: retire is a single-cycle pulse following a handshake
  assert_retire_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire);
  assert_retire_after_hs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> ($past(wr_valid && wr_ready) && !wr_valid));
  // R3 / R10: a fault outcome never coincides with a beat
  assert_no_beat_on_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_fault || hard_trap) |-> !wr_valid);
  // R10: only one fault kind exists per build
  assert_one_fault_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_fault && hard_trap));
  // R5: beats past the first carry zero
  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && beat != '0) |-> (wr_data == '0));
  // R4: every beat address is word aligned
  assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[LANE_SH-1:0] == '0));
endmodule

// File: tb/qstore_seq_test.sv
module qstore_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] insn = '0, base_val = '0, src_val = '0;
  logic        wr_ready = 1'b1;

  logic        busy, wr_valid, retire, addr_fault, hard_trap;
  logic [31:0] wr_addr, wr_data;
  logic        t_busy, t_valid, t_retire, t_fault, t_trap;
  logic [31:0] t_addr, t_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  qstore_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .base_val(base_val),
    .src_val(src_val), .busy(busy), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .retire(retire),
    .addr_fault(addr_fault), .hard_trap(hard_trap)
  );

  qstore_seq #(.STRICT_TRAP(1'b1)) uut_trap (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .base_val(base_val),
    .src_val(src_val), .busy(t_busy), .wr_valid(t_valid), .wr_ready(wr_ready),
    .wr_addr(t_addr), .wr_data(t_data), .retire(t_retire),
    .addr_fault(t_fault), .hard_trap(t_trap)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int rdy_mode = 0;
  int retire_cnt = 0;
  bit done = 1'b0;

  // behavioural reference
  logic [63:0] ref_q[$];
  bit          m_busy = 1'b0, m_retire = 1'b0, m_fault = 1'b0;
  logic [31:0] mem [16];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit old_busy;
    logic [31:0] ea;
    if (!rst_n) begin
      ref_q.delete();
      m_busy = 0; m_retire = 0; m_fault = 0;
    end else begin
      if (wr_valid && wr_ready) mem[wr_addr[5:2]] = wr_data;
      if (retire) retire_cnt++;
      old_busy = m_busy;
      m_retire = 0;
      m_fault = 0;
      if (old_busy) begin
        if (wr_ready && ref_q.size() > 0) begin
          void'(ref_q.pop_front());
          if (ref_q.size() == 0) begin
            m_busy = 0;
            m_retire = 1;
          end
        end
      end else if (start && insn[31:26] == 6'h1F) begin
        ea = base_val + {{16{insn[15]}}, insn[15:0]};
        if (ea[3:0] != 4'h0) m_fault = 1;
        else begin
          for (int k = 0; k < 4; k++)
            ref_q.push_back({ea + 32'(4*k), (k == 0) ? src_val : 32'h0});
          m_busy = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(wr_valid == m_busy, "R4 valid", 32'(wr_valid), 32'(m_busy));
      chk(busy == m_busy, "R8 busy", 32'(busy), 32'(m_busy));
      if (m_busy && ref_q.size() > 0) begin
        chk(wr_addr == ref_q[0][63:32], "R4 addr", wr_addr, ref_q[0][63:32]);
        chk(wr_data == ref_q[0][31:0], "R5 data", wr_data, ref_q[0][31:0]);
        chk(t_addr == ref_q[0][63:32], "R4 addr strict", t_addr, ref_q[0][63:32]);
      end
      chk(retire == m_retire, "R7 retire", 32'(retire), 32'(m_retire));
      chk(addr_fault == m_fault, "R3 fault", 32'(addr_fault), 32'(m_fault));
      chk(t_trap == m_fault, "R10 trap", 32'(t_trap), 32'(m_fault));
      chk(t_fault == 1'b0, "R10 no exc in strict", 32'(t_fault), 32'h0);
      chk(t_valid == m_busy && t_retire == m_retire, "R10 strict beats",
          32'({t_valid, t_retire}), 32'({m_busy, m_retire}));
    end
    if (rdy_mode == 0) wr_ready = 1'b1;
    else               wr_ready = (cyc % 3) != 0;
    if (cyc > 100000 && !done) begin
      chk(1'b0, "watchdog", 32'(cyc), 32'h0);
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic issue(input logic [31:0] i, input logic [31:0] b, input logic [31:0] s);
    @(negedge clk);
    start = 1'b1; insn = i; base_val = b; src_val = s;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk);
    while (m_busy && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input logic [4:0] bs, input logic [4:0] rt, input logic [15:0] off);
    return {6'h1F, bs, rt, off};
  endfunction

  initial begin
    int r0;
    for (int k = 0; k < 16; k++) mem[k] = 32'h1111_0000 + 32'(k);
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!busy && !wr_valid && !retire && !addr_fault && !t_trap, "R9 reset",
        32'({busy, wr_valid, retire, addr_fault, t_trap}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !wr_valid, "R9 after reset", 32'({busy, wr_valid}), 32'h0);

    // R5: zero store clears 16 preloaded bytes at 0x...400 (mem index 0..3)
    mem[0] = 32'hDEAD_BEEF; mem[1] = 32'hCAFE_F00D; mem[2] = 32'h1234_5678; mem[3] = 32'h9ABC_DEF0;
    r0 = retire_cnt;
    issue(32'h7C40_0000, 32'h8000_0400, 32'h0);
    wait_idle();
    for (int k = 0; k < 4; k++) chk(mem[k] == 32'h0, "R5 zero store", mem[k], 32'h0);
    chk(retire_cnt == r0 + 1, "R7 one retire", 32'(retire_cnt - r0), 32'd1);

    // R2/R5/R6: negative offset, non-zero source, stalling ready
    rdy_mode = 1;
    issue(mk(5'd2, 5'd3, 16'hFFF0), 32'h0000_1030, 32'hA5A5_1234);
    wait_idle();
    chk(mem[8] == 32'hA5A5_1234, "R2 R5 beat0 at ea", mem[8], 32'hA5A5_1234);
    chk(mem[11] == 32'h0, "R5 beat3 zero", mem[11], 32'h0);

    // R3/R10: misaligned stores write nothing
    mem[4] = 32'h5555_5555;
    issue(mk(5'd2, 5'd0, 16'h0004), 32'h0000_0010, 32'hFFFF_FFFF);
    wait_idle();
    chk(mem[4] == 32'h5555_5555 && mem[5] == 32'h1111_0005, "R3 no partial write", mem[4], 32'h5555_5555);
    issue(mk(5'd2, 5'd0, 16'h0001), 32'h0000_0010, 32'h0);
    wait_idle();

    // R1: a foreign opcode is ignored
    r0 = retire_cnt;
    issue({6'h2B, 5'd2, 5'd0, 16'h0000}, 32'h0000_0010, 32'h7777_7777);
    wait_idle();
    chk(retire_cnt == r0 && mem[4] == 32'h5555_5555, "R1 foreign opcode ignored",
        32'(retire_cnt - r0), 32'h0);

    // R8: start while busy is ignored
    rdy_mode = 0;
    r0 = retire_cnt;
    issue(mk(5'd1, 5'd0, 16'h0000), 32'h0000_0020, 32'h0BAD_0001);
    issue(mk(5'd1, 5'd0, 16'h0000), 32'h0000_0030, 32'h0BAD_0002);
    wait_idle();
    chk(retire_cnt == r0 + 1, "R8 busy start ignored", 32'(retire_cnt - r0), 32'd1);
    chk(mem[12] == 32'h1111_000C, "R8 second store absent", mem[12], 32'h1111_000C);

    // R9: back-to-back stores restart at beat 0
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      start = 1'b1; insn = mk(5'd1, 5'd0, 16'h0000);
      base_val = 32'h0000_0100 + 32'(16*n); src_val = 32'hC0DE_0000 + 32'(n);
      @(negedge clk);
      start = 1'b0;
      while (!retire) @(negedge clk);
    end
    wait_idle();
    chk(mem[8] == 32'hC0DE_0002, "R9 restart beat0", mem[8], 32'hC0DE_0002);

    finish_run();
  end
endmodule